// File: doc/BRIEF.md
# External Bus Cycle Sequencer with READY Wait States

The block turns one local request into one read or write cycle on a simple external bus. A cycle always walks the same chain of phases: an address setup phase, an optional one-clock command delay, a command phase with the read or write strobe low, a hold phase, and a single acknowledge clock. The chip select stays low from the first setup clock to the last hold clock. Address and write data stay still for that whole window. The length of every phase comes with the request, so no two cycles need to share a timing.

The command phase has a minimum length. Once that minimum has run, the block can stretch the cycle with wait states until the external device raises its READY input. Each request picks the active level of READY. It also picks how READY is taken in: either straight from the pin, which gives the shortest cycle, or through a two-flop synchronizer, which costs two extra wait states. READY is evaluated only from the last clock of the minimum command length until the strobe rises. A counter of wait states ends a cycle whose READY never comes, and flags it as timed out.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, so holding a request back just keeps `req_valid` high until the sequencer is free. The response side is a single-clock strobe with no back-pressure: the requester must take `rsp_rdata` and `rsp_timeout` in the clock in which `rsp_valid` is high.

Top module: `xbus_seq`

## Requirements
- R1: Out of reset, and whenever no cycle is running, `req_ready` is 1, `rsp_valid` is 0 and `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1. A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the clock after the acknowledge.
- R2: After a request is taken, `bus_cs_n` is low for exactly `req_setup` + `req_dly` clocks before the strobe falls. Only `bus_rd_n` falls for a read (`req_write`=0), and only `bus_wr_n` falls for a write. `bus_addr` equals the request address on every clock in which `bus_cs_n` is low.
- R3: With `req_rdy_en`=0 the strobe is low for exactly `req_cmd`+1 clocks, whatever READY does.
- R4: With `req_rdy_en`=1 and `req_rdy_async`=0, suppose READY is active from strobe clock D onward, where strobe clock 0 is the first clock with the strobe low. The strobe is then low for max(`req_cmd`, D)+1 clocks.
- R5: With `req_rdy_en`=1 and `req_rdy_async`=1, under the same READY pattern, the strobe is low for max(`req_cmd`, D+2)+1 clocks. That is two wait states more than R4 whenever D ≥ `req_cmd`.
- R6: `req_rdy_low`=0 makes `bus_rdy`=1 the active level. `req_rdy_low`=1 makes `bus_rdy`=0 the active level. Either setting gives the same cycle timing for the same active/inactive pattern.
- R7: READY that is active only in strobe clocks before the first sample point (clock `req_cmd`, or `req_cmd`−2 on the input side in asynchronous mode) has no effect on the cycle.
- R8: With `req_rdy_en`=1, a cycle that has inserted TMO_CLKS wait states without seeing READY ends anyway. Its strobe is then low for `req_cmd`+TMO_CLKS+1 clocks, and `rsp_timeout` is 1 during `rsp_valid`. If READY is seen at that same last sample, it wins and `rsp_timeout` is 0.
- R9: After the strobe rises, `bus_cs_n` stays low for exactly `req_hold` clocks. In the next clock `bus_cs_n` is 1 and `rsp_valid` is 1, and `rsp_valid` is 0 again in the clock after that.
- R10: For a read, `rsp_rdata` equals the value of `bus_rdata` in the last strobe-low clock.
- R11: During a write, `bus_wdata_oe` is 1 and `bus_wdata` equals the request's write data on every clock with `bus_cs_n` low. During a read, `bus_wdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request taken when valid is also high |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_setup | input | 2 | Address setup clocks (0 to 3) |
| req_dly | input | 1 | One extra clock before the strobe |
| req_cmd | input | 3 | Minimum strobe length minus one (0 to 7) |
| req_hold | input | 2 | Hold clocks after the strobe (0 to 3) |
| req_rdy_en | input | 1 | 1 = stretch the strobe until READY |
| req_rdy_low | input | 1 | 1 = READY active low |
| req_rdy_async | input | 1 | 1 = take READY through the synchronizer |
| rsp_valid | output | 1 | One-clock completion strobe |
| rsp_rdata | output | DW | Captured read data |
| rsp_timeout | output | 1 | Cycle ended by the wait-state limit |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DW | External write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DW | External read data |
| bus_rdy | input | 1 | External READY |

## Verification
READY acceptance and the wait-state timeout can fall on the same sample edge. That happens when READY first becomes visible at exactly the TMO_CLKS-th wait. A directed case drives READY from strobe clock `req_cmd`+TMO_CLKS, so the two events coincide. It is judged by a strobe length of `req_cmd`+TMO_CLKS+1 with `rsp_timeout` low, against the same length with the flag high when READY never comes. A second coincidence is READY arriving exactly in the first sample clock. It is checked against a pulse that ends one clock earlier, which must be ignored.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  localparam int SETUP_W = 2;
  localparam int CMD_W   = 3;
  localparam int HOLD_W  = 2;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic               dly;
    logic [CMD_W-1:0]   cmd;
    logic [HOLD_W-1:0]  hold;
    logic               rdy_en;
    logic               rdy_low;
    logic               rdy_async;
  } cyc_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_DELAY, PH_CMD, PH_HOLD, PH_ACK
  } phase_e;
endpackage

// File: rtl/xbus_seq_rdy.sv
// READY front end: raw pin path or two-flop synchronizer, then polarity fix.
module xbus_seq_rdy (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic low_act,
  input  logic use_sync,
  output logic act
);
  logic ff1, ff2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1 <= 1'b0;
      ff2 <= 1'b0;
    end else begin
      ff1 <= pin;
      ff2 <= ff1;
    end
  end

  // polarity is applied after the flops so the synchronizer never depends on cfg
  assign act = (use_sync ? ff2 : pin) ^ low_act;
endmodule

// File: rtl/xbus_seq_ctl.sv
// Phase sequencer: setup, delay, command with wait states, hold, acknowledge.
module xbus_seq_ctl
  import xbus_seq_pkg::*;
#(
  parameter int TMO_CLKS = 255
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  cyc_cfg_t cfg_in,
  input  logic     rdy_act,
  output cyc_cfg_t cfg_q,
  output phase_e   phase,
  output logic     cmd_done,
  output logic     tmo_q
);
  localparam int CNT_W = (CMD_W > SETUP_W) ? ((CMD_W > HOLD_W) ? CMD_W : HOLD_W)
                                           : ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);
  localparam int TW = $clog2(TMO_CLKS + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    wcnt;
  logic             at_sample, tmo_hit;

  always_comb begin
    at_sample = (phase == PH_CMD) && (cnt == CNT_W'(cfg_q.cmd));
    tmo_hit   = cfg_q.rdy_en && !rdy_act && (wcnt == TW'(TMO_CLKS));
    cmd_done  = at_sample && (!cfg_q.rdy_en || rdy_act || tmo_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      wcnt  <= '0;
      tmo_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          cfg_q <= cfg_in;
          cnt   <= '0;
          wcnt  <= '0;
          tmo_q <= 1'b0;
          phase <= (cfg_in.setup != '0) ? PH_SETUP : (cfg_in.dly ? PH_DELAY : PH_CMD);
        end
        PH_SETUP: begin
          if (cnt + ONE == CNT_W'(cfg_q.setup)) begin
            cnt   <= '0;
            phase <= cfg_q.dly ? PH_DELAY : PH_CMD;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_DELAY: begin
          cnt   <= '0;
          phase <= PH_CMD;
        end
        PH_CMD: begin
          if (!at_sample) begin
            cnt <= cnt + ONE;
          end else if (cmd_done) begin
            cnt   <= '0;
            tmo_q <= tmo_hit;
            phase <= (cfg_q.hold != '0) ? PH_HOLD : PH_ACK;
          end else begin
            wcnt <= wcnt + TW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt + ONE == CNT_W'(cfg_q.hold)) begin
            cnt   <= '0;
            phase <= PH_ACK;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_ACK:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int TMO_CLKS = 255
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic               req_write,
  input  logic [SETUP_W-1:0] req_setup,
  input  logic               req_dly,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [HOLD_W-1:0]  req_hold,
  input  logic               req_rdy_en,
  input  logic               req_rdy_low,
  input  logic               req_rdy_async,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_timeout,
  output logic [AW-1:0]      bus_addr,
  output logic               bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic [DW-1:0]      bus_wdata,
  output logic               bus_wdata_oe,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_rdy
);
  cyc_cfg_t cfg_in, cfg_q;
  phase_e   phase;
  logic     start, cmd_done, tmo_q, rdy_act, cs_act, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign cfg_in = '{setup: req_setup, dly: req_dly, cmd: req_cmd, hold: req_hold,
                    rdy_en: req_rdy_en, rdy_low: req_rdy_low, rdy_async: req_rdy_async};
  assign start  = req_valid && req_ready;

  xbus_seq_rdy u_rdy (
    .clk(clk), .rst_n(rst_n), .pin(bus_rdy),
    .low_act(cfg_q.rdy_low), .use_sync(cfg_q.rdy_async), .act(rdy_act)
  );

  xbus_seq_ctl #(.TMO_CLKS(TMO_CLKS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in), .rdy_act(rdy_act),
    .cfg_q(cfg_q), .phase(phase), .cmd_done(cmd_done), .tmo_q(tmo_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      if (cmd_done && !wr_q) rsp_rdata <= bus_rdata;
    end
  end

  assign cs_act       = (phase == PH_SETUP) || (phase == PH_DELAY) ||
                        (phase == PH_CMD)   || (phase == PH_HOLD);
  assign req_ready    = (phase == PH_IDLE);
  assign rsp_valid    = (phase == PH_ACK);
  assign rsp_timeout  = rsp_valid && tmo_q;
  assign bus_addr     = addr_q;
  assign bus_cs_n     = !cs_act;
  assign bus_rd_n     = !((phase == PH_CMD) && !wr_q);
  assign bus_wr_n     = !((phase == PH_CMD) && wr_q);
  assign bus_wdata    = wdata_q;
  assign bus_wdata_oe = cs_act && wr_q;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_timeout,
  input logic [AW-1:0] bus_addr,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_wdata_oe
);
  assert_take_then_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  assert_addr_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> $stable(bus_addr));

  assert_timeout_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_valid);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ack_after_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (bus_cs_n && $past(!bus_cs_n)));

  assert_drive_only_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_oe |-> (!bus_cs_n && bus_rd_n));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .bus_addr(bus_addr),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_wdata_oe(bus_wdata_oe)
);

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TMO = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_dly;
  logic req_rdy_en, req_rdy_low, req_rdy_async;
  logic [1:0] req_setup, req_hold;
  logic [2:0] req_cmd;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, bus_wdata, bus_rdata;
  logic rsp_valid, rsp_timeout, bus_cs_n, bus_rd_n, bus_wr_n, bus_wdata_oe, bus_rdy;

  xbus_seq #(.AW(AW), .DW(DW), .TMO_CLKS(TMO)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rdy_seen(int k, bit as, int d, int pw);
    int j = as ? k - 2 : k;
    return (d >= 0) && (j >= d) && ((pw == 0) || (j < d + pw));
  endfunction

  function automatic int exp_len(int cm, bit en, bit as, int d, int pw, output bit tmo);
    tmo = 1'b0;
    if (!en) return cm + 1;
    for (int k = cm; k <= cm + TMO; k++)
      if (rdy_seen(k, as, d, pw)) return k + 1;
    tmo = 1'b1;
    return cm + TMO + 1;
  endfunction

  task automatic run(bit wr, int su, int dl, int cm, int ho, bit en, bit low, bit as,
                     int d, int pw, string nm);
    int pre = 0, slen = 0, post = 0, cyc = 0, errs = 0, elen;
    bit done = 0, ended = 0, etmo, got_tmo = 0, strobe, other;
    logic [DW-1:0] last_rd = '0, got_rd = '0;
    logic [AW-1:0] a;
    logic [DW-1:0] w;
    string lt;
    @(negedge clk);
    bus_rdy = low;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, {"R1 idle before ", nm}, int'(req_ready), 1);
    a = AW'($urandom); w = DW'($urandom);
    req_addr = a; req_wdata = w; req_write = wr;
    req_setup = 2'(su); req_dly = 1'(dl); req_cmd = 3'(cm); req_hold = 2'(ho);
    req_rdy_en = en; req_rdy_low = low; req_rdy_async = as;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 200) begin
      cyc++;
      strobe = wr ? bus_wr_n : bus_rd_n;
      other  = wr ? bus_rd_n : bus_wr_n;
      if (!other) errs++;
      if (rsp_valid) begin
        done = 1; got_tmo = rsp_timeout; got_rd = rsp_rdata;
        bus_rdy = low;
        if (!bus_cs_n) errs++;
      end else if (!bus_cs_n) begin
        if (bus_addr != a || req_ready || bus_wdata_oe != wr) errs++;
        if (wr && bus_wdata != w) errs++;
        if (!strobe) begin
          if (ended) errs++;
          bus_rdy = rdy_seen(slen, 1'b0, d, pw) ^ low;
          bus_rdata = DW'($urandom);
          last_rd = bus_rdata;
          slen++;
        end else if (slen == 0) begin
          pre++;
        end else begin
          ended = 1; post++; bus_rdy = low;
        end
      end else begin
        errs++;
      end
      if (!done) @(negedge clk);
    end
    elen = exp_len(cm, en, as, d, pw, etmo);
    lt = !en ? "R3" : (as ? "R5" : "R4");
    chk(done, {"R9 ack seen ", nm}, int'(done), 1);
    chk(errs == 0, {"R2 R11 R1 bus signals ", nm}, errs, 0);
    chk(pre == su + dl, {"R2 setup clocks ", nm}, pre, su + dl);
    chk(slen == elen, {lt, " strobe length ", nm}, slen, elen);
    chk(got_tmo == etmo, {"R8 timeout flag ", nm}, int'(got_tmo), int'(etmo));
    chk(post == ho, {"R9 hold clocks ", nm}, post, ho);
    if (!wr) chk(got_rd == last_rd, {"R10 read data ", nm}, int'(got_rd), int'(last_rd));
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, {"R9 R1 single ack ", nm},
        int'({rsp_valid, req_ready}), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_dly = 1'b0;
    req_rdy_en = 1'b0; req_rdy_low = 1'b0; req_rdy_async = 1'b0;
    req_setup = '0; req_hold = '0; req_cmd = '0; req_addr = '0; req_wdata = '0;
    bus_rdata = '0; bus_rdy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && bus_cs_n && bus_rd_n && bus_wr_n && !rsp_valid, "R1 reset state",
        int'({req_ready, bus_cs_n, bus_rd_n, bus_wr_n, rsp_valid}), 5'b11110);

    // wait-state count for a fixed READY delay, both modes
    run(0, 0, 0, 1, 0, 1, 0, 0, 3, 0, "R4 sync d3");
    run(0, 0, 0, 1, 0, 1, 0, 1, 3, 0, "R5 async d3");
    // both polarities
    run(0, 1, 0, 0, 1, 1, 1, 0, 2, 0, "R6 low sync");
    run(0, 1, 0, 0, 1, 1, 1, 1, 2, 0, "R6 low async");
    run(1, 0, 1, 2, 0, 1, 0, 1, 4, 0, "R6 high async");
    // READY before the sample point
    run(0, 0, 0, 5, 0, 1, 0, 0, 0, 0, "R7 early level");
    run(0, 0, 0, 5, 0, 1, 0, 0, 0, 5, "R7 pulse ends before sample");
    run(0, 0, 0, 5, 0, 1, 1, 0, 0, 6, "R7 pulse at sample");
    // fixed length ignores READY
    run(0, 0, 0, 3, 0, 0, 0, 0, -1, 0, "R3 no ready");
    run(1, 2, 0, 2, 2, 0, 1, 1, 0, 0, "R3 early ready");
    // timeout and the coincidence with READY
    run(0, 0, 0, 2, 0, 1, 0, 0, -1, 0, "R8 never");
    run(0, 0, 0, 2, 0, 1, 0, 0, 2 + TMO, 0, "R8 ready at limit");
    run(0, 0, 0, 2, 0, 1, 0, 1, TMO, 0, "R8 async at limit");
    // long write with all phases
    run(1, 3, 1, 7, 3, 1, 0, 0, 9, 0, "R11 R2 full write");

    for (int i = 0; i < 40; i++) begin
      int dd = int'($urandom_range(0, 10)) - 1;
      run(1'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
          ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), dd, 0, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule